// File: doc/BRIEF.md
# Control Register Page Decoder for a Secondary Byte Processor

This block sits between an 8-bit secondary processor and the control and I/O register page of a 16-bit main bus. Each byte access carries a 16-bit offset inside that page, a write flag and write data. Bits [15:8] of the offset select a register group. Bits [7:0] then decide whether the access reaches a real register, falls into a hole, or is an invalid access.

Real registers are reached through plain strobes. These go to the I/O chip and to the cartridge timing register, and they update three local latches: the bus-request latch, the reset-control latch and the boot-ROM map select. A read from a hole returns a fixed open-bus byte, and a write to a hole is dropped. An access to an undefined group returns 0xFF. Unless the force-acknowledge input is high, it also sets a sticky lockup flag, which stops the requester from issuing any further access until a synchronous reset.

Accesses use a valid/ready handshake. An access is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only while the lockup flag is set, and a held request then waits. The read response comes back on the next cycle as a one-cycle `rsp_valid` pulse and cannot be stalled. The requester must be able to take it.

Top module: `ctrl_page_decoder`

## Requirements
- R1: An accepted read to group 0x00 with offset bits [7:5] zero pulses `io_rd_en` in the accept cycle with `io_index` = offset bits [4:1]. The response data equals the `io_rdata` value present in that cycle.
- R2: An accepted read to a hole returns 0x00 when offset bit 0 is 1 and 0xFF when it is 0. Holes are: group 0x00 with bits [7:5] nonzero, group 0x11 at an odd offset, every read of groups 0x12 and 0x41, and the reserved groups 0x10, 0x20, 0x40, 0x44 and 0x50. A write to any hole changes no output and asserts no strobe.
- R3: `io_wr_en` pulses only for an accepted write to group 0x00 whose offset low byte ANDed with 0xE1 equals 0x01. It then carries `io_index` = bits [4:1] and `io_wdata` = the write data.
- R4: A read of group 0x11 at an even offset returns 0xFF. A write at an even offset loads write-data bit 0 into `bus_req`.
- R5: A write to group 0x12 at an even offset loads write-data bit 0 into `sys_reset`. An odd-offset write leaves it unchanged.
- R6: A write to group 0x41 at an odd offset sets `map_cart` to write-data bit 0, where 1 maps the cartridge and 0 maps the boot ROM. An even-offset write leaves it unchanged.
- R7: A read of group 0x30 returns `timer_rdata[15:8]` at an even offset and `timer_rdata[7:0]` at an odd offset. Any write to group 0x30 pulses `timer_wr_en`, passing offset bits [7:0] and the write data.
- R8: An accepted access to any group not named in R1 to R7 returns 0xFF if it is a read and drives no strobe. When `force_ack` is low it sets `lockup` on the next cycle. `lockup` then stays set and holds `req_ready` low until reset.
- R9: While `force_ack` is high, an invalid access does not set `lockup`.
- R10: After reset, `bus_req`, `sys_reset`, `map_cart`, `lockup` and `rsp_valid` are 0 and `req_ready` is 1.
- R11: `rsp_valid` pulses exactly one cycle after each accepted read and at no other time. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| force_ack | input | 1 | Invalid accesses do not lock up when high |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access can be accepted (low while locked) |
| req_addr | input | 16 | Byte offset inside the control page |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after accept |
| rsp_rdata | output | 8 | Read data |
| io_rd_en | output | 1 | I/O chip read strobe |
| io_wr_en | output | 1 | I/O chip write strobe |
| io_index | output | 4 | I/O chip register index |
| io_wdata | output | 8 | I/O chip write data |
| io_rdata | input | 8 | I/O chip read data, same cycle as strobe |
| timer_rdata | input | 16 | Cartridge timing register value |
| timer_wr_en | output | 1 | Timing register write strobe |
| timer_offset | output | 8 | Offset low byte for timing write |
| timer_wdata | output | 8 | Timing register write data |
| bus_req | output | 1 | Bus-request latch |
| sys_reset | output | 1 | Reset-control latch |
| map_cart | output | 1 | 1 = cartridge mapped, 0 = boot ROM mapped |
| lockup | output | 1 | Sticky invalid-access flag |

## Verification
The in-line assertions check properties that hold on every cycle. The lockup flag is sticky, and `req_ready` stays low while it is set. Force-acknowledge blocks lockup. Strobes are mutually exclusive. The I/O write strobe fires only for odd offsets in the low range. The map select is stable unless an odd-offset boot-select write is accepted. Responses pair one-to-one with accepted reads. The bench scenarios are needed for the data itself: the open-bus pattern in each kind of hole, the byte lane selection of the timing register, latch contents after mixed odd and even writes, and recovery from lockup through reset.

// File: rtl/ctrl_page_pkg.sv
package ctrl_page_pkg;

  typedef enum logic [2:0] {
    GRP_IO, GRP_BREQ, GRP_RST, GRP_TIMER, GRP_BOOT, GRP_RSVD, GRP_BAD
  } grp_e;

  typedef struct packed {
    grp_e grp;
    logic io_rd;
    logic io_wr;
    logic breq_rd;
    logic breq_wr;
    logic rst_wr;
    logic boot_wr;
    logic tmr_rd;
    logic tmr_wr;
    logic hole_rd;
    logic bad;
  } dec_t;

  localparam logic [7:0] PG_IO    = 8'h00;
  localparam logic [7:0] PG_BREQ  = 8'h11;
  localparam logic [7:0] PG_RST   = 8'h12;
  localparam logic [7:0] PG_TIMER = 8'h30;
  localparam logic [7:0] PG_BOOT  = 8'h41;

  localparam int NUM_RSVD = 5;
  localparam logic [NUM_RSVD*8-1:0] RSVD_LIST = {8'h10, 8'h20, 8'h40, 8'h44, 8'h50};

  localparam logic [7:0] IO_WR_MASK  = 8'hE1;
  localparam logic [7:0] IO_WR_MATCH = 8'h01;

endpackage

// File: rtl/ctrl_page_classify.sv
module ctrl_page_classify
  import ctrl_page_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output dec_t              dec
);
  localparam int PAGE_LSB = ADDR_W - 8;

  logic [7:0] page;
  logic [7:0] low;
  logic       odd;
  logic [NUM_RSVD-1:0] rsvd_hit;

  assign page = addr[ADDR_W-1:PAGE_LSB];
  assign low  = addr[7:0];
  assign odd  = addr[0];

  for (genvar g = 0; g < NUM_RSVD; g++) begin : g_rsvd
    assign rsvd_hit[g] = (page == RSVD_LIST[g*8 +: 8]);
  end

  always_comb begin
    dec = '0;
    dec.grp = GRP_BAD;
    unique case (page)
      PG_IO: begin
        dec.grp   = GRP_IO;
        dec.io_rd = !wr && (low[7:5] == 3'b000);
        dec.io_wr = wr && ((low & IO_WR_MASK) == IO_WR_MATCH);
      end
      PG_BREQ: begin
        dec.grp     = GRP_BREQ;
        dec.breq_rd = !wr && !odd;
        dec.breq_wr = wr && !odd;
      end
      PG_RST: begin
        dec.grp    = GRP_RST;
        dec.rst_wr = wr && !odd;
      end
      PG_TIMER: begin
        dec.grp    = GRP_TIMER;
        dec.tmr_rd = !wr;
        dec.tmr_wr = wr;
      end
      PG_BOOT: begin
        dec.grp     = GRP_BOOT;
        dec.boot_wr = wr && odd;
      end
      default: begin
        if (|rsvd_hit) dec.grp = GRP_RSVD;
        else           dec.bad = 1'b1;
      end
    endcase
    dec.hole_rd = !wr && !dec.bad && !dec.io_rd && !dec.breq_rd && !dec.tmr_rd;
  end
endmodule

// File: rtl/ctrl_page_latches.sv
module ctrl_page_latches
  import ctrl_page_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  dec_t dec,
  input  logic wbit,
  output logic bus_req,
  output logic sys_reset,
  output logic map_cart
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      sys_reset <= 1'b0;
      map_cart  <= 1'b0;
    end else if (fire) begin
      if (dec.breq_wr) bus_req   <= wbit;
      if (dec.rst_wr)  sys_reset <= wbit;
      if (dec.boot_wr) map_cart  <= wbit;
    end
  end

  // R6: map select moves only on an accepted odd boot-select write
  a_r6_map_hold: assert property (@(posedge clk) disable iff (rst)
    !(fire && dec.boot_wr) |=> $stable(map_cart));
  // R5: reset latch moves only on an accepted even reset write
  a_r5_rst_hold: assert property (@(posedge clk) disable iff (rst)
    !(fire && dec.rst_wr) |=> $stable(sys_reset));
  // R4: bus-request latch moves only on an accepted even write
  a_r4_breq_hold: assert property (@(posedge clk) disable iff (rst)
    !(fire && dec.breq_wr) |=> $stable(bus_req));
endmodule

// File: rtl/ctrl_page_lockup.sv
module ctrl_page_lockup (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic bad,
  input  logic force_ack,
  output logic lockup
);
  always_ff @(posedge clk) begin
    if (rst)                            lockup <= 1'b0;
    else if (fire && bad && !force_ack) lockup <= 1'b1;
  end

  a_r8_lockup_sticky: assert property (@(posedge clk) disable iff (rst)
    lockup |=> lockup);
  a_r9_force_blocks: assert property (@(posedge clk) disable iff (rst)
    (force_ack && !lockup) |=> !lockup);
endmodule

// File: rtl/ctrl_page_decoder.sv
module ctrl_page_decoder
  import ctrl_page_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 4,
  parameter int TMR_W   = 16,
  parameter logic [DATA_W-1:0] OPEN_EVEN = 8'hFF,
  parameter logic [DATA_W-1:0] OPEN_ODD  = 8'h00,
  parameter logic [DATA_W-1:0] BAD_DATA  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              force_ack,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              io_rd_en,
  output logic              io_wr_en,
  output logic [IDX_W-1:0]  io_index,
  output logic [DATA_W-1:0] io_wdata,
  input  logic [DATA_W-1:0] io_rdata,
  input  logic [TMR_W-1:0]  timer_rdata,
  output logic              timer_wr_en,
  output logic [7:0]        timer_offset,
  output logic [DATA_W-1:0] timer_wdata,
  output logic              bus_req,
  output logic              sys_reset,
  output logic              map_cart,
  output logic              lockup
);
  localparam int TMR_HI = TMR_W - DATA_W;

  dec_t dec;
  logic fire;
  logic [DATA_W-1:0] rd_mux;

  ctrl_page_classify #(.ADDR_W(ADDR_W)) u_classify (
    .addr(req_addr), .wr(req_write), .dec(dec)
  );

  ctrl_page_lockup u_lockup (
    .clk(clk), .rst(rst), .fire(fire), .bad(dec.bad),
    .force_ack(force_ack), .lockup(lockup)
  );

  ctrl_page_latches u_latches (
    .clk(clk), .rst(rst), .fire(fire), .dec(dec), .wbit(req_wdata[0]),
    .bus_req(bus_req), .sys_reset(sys_reset), .map_cart(map_cart)
  );

  assign req_ready    = !lockup;
  assign fire         = req_valid && req_ready;
  assign io_rd_en     = fire && dec.io_rd;
  assign io_wr_en     = fire && dec.io_wr;
  assign io_index     = req_addr[IDX_W:1];
  assign io_wdata     = req_wdata;
  assign timer_wr_en  = fire && dec.tmr_wr;
  assign timer_offset = req_addr[7:0];
  assign timer_wdata  = req_wdata;

  always_comb begin
    rd_mux = BAD_DATA;
    if (dec.io_rd)        rd_mux = io_rdata;
    else if (dec.breq_rd) rd_mux = 8'hFF;
    else if (dec.tmr_rd)  rd_mux = req_addr[0] ? timer_rdata[DATA_W-1:0]
                                               : timer_rdata[TMR_HI +: DATA_W];
    else if (dec.hole_rd) rd_mux = req_addr[0] ? OPEN_ODD : OPEN_EVEN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= fire && !req_write;
      if (fire && !req_write) rsp_rdata <= rd_mux;
    end
  end

  a_r11_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
    (fire && !req_write) |=> rsp_valid);
  a_r11_no_stray_rsp: assert property (@(posedge clk) disable iff (rst)
    !(fire && !req_write) |=> !rsp_valid);
  a_r8_locked_not_ready: assert property (@(posedge clk) disable iff (rst)
    lockup |-> !req_ready);
  a_r3_io_wr_odd_low: assert property (@(posedge clk) disable iff (rst)
    io_wr_en |-> (req_addr[0] && req_addr[7:5] == 3'b000 && req_addr[ADDR_W-1:ADDR_W-8] == 8'h00));
  a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({io_rd_en, io_wr_en, timer_wr_en}));
endmodule

// File: tb/ctrl_page_decoder_tb_top.sv
module ctrl_page_decoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic force_ack = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [15:0] req_addr = '0;
  logic req_write = 1'b0;
  logic [7:0] req_wdata = '0;
  logic rsp_valid;
  logic [7:0] rsp_rdata;
  logic io_rd_en, io_wr_en;
  logic [3:0] io_index;
  logic [7:0] io_wdata;
  logic [7:0] io_rdata;
  logic [15:0] timer_rdata = 16'h0000;
  logic timer_wr_en;
  logic [7:0] timer_offset, timer_wdata;
  logic bus_req, sys_reset, map_cart, lockup;

  int checks = 0;
  int failures = 0;
  logic m_breq, m_rst, m_map, m_lock;

  always #2.5 clk = ~clk;
  assign io_rdata = {4'h6, io_index} ^ 8'h3C;

  ctrl_page_decoder dut_i (
    .clk(clk), .rst(rst), .force_ack(force_ack),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .io_rd_en(io_rd_en), .io_wr_en(io_wr_en), .io_index(io_index),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .timer_rdata(timer_rdata),
    .timer_wr_en(timer_wr_en), .timer_offset(timer_offset), .timer_wdata(timer_wdata),
    .bus_req(bus_req), .sys_reset(sys_reset), .map_cart(map_cart), .lockup(lockup)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_rsvd(input logic [7:0] p);
    return p == 8'h10 || p == 8'h20 || p == 8'h40 || p == 8'h44 || p == 8'h50;
  endfunction

  function automatic bit is_bad(input logic [7:0] p);
    return !(p == 8'h00 || p == 8'h11 || p == 8'h12 || p == 8'h30 || p == 8'h41 || is_rsvd(p));
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a, input logic [15:0] t);
    logic [7:0] p = a[15:8];
    logic [7:0] hole = a[0] ? 8'h00 : 8'hFF;
    if (is_bad(p)) return 8'hFF;                                        // R8
    if (p == 8'h00) return (a[7:5] == 0) ? ({4'h6, a[4:1]} ^ 8'h3C) : hole; // R1, R2
    if (p == 8'h11) return a[0] ? hole : 8'hFF;                          // R4, R2
    if (p == 8'h30) return a[0] ? t[7:0] : t[15:8];                      // R7
    return hole;                                                         // R2
  endfunction

  task automatic check_latches(input string tag);
    chk(bus_req == m_breq,   {tag, " R4 bus_req"},   bus_req,   m_breq);
    chk(sys_reset == m_rst,  {tag, " R5 sys_reset"}, sys_reset, m_rst);
    chk(map_cart == m_map,   {tag, " R6 map_cart"},  map_cart,  m_map);
    chk(lockup == m_lock,    {tag, " R8 lockup"},    lockup,    m_lock);
    chk(req_ready == !m_lock, {tag, " R8 req_ready"}, req_ready, !m_lock);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; req_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_breq = 0; m_rst = 0; m_map = 0; m_lock = 0;
    #1;
    check_latches("R10 reset");
    chk(rsp_valid == 1'b0, "R10 rsp_valid", rsp_valid, 0);
  endtask

  task automatic access(input logic [15:0] a, input logic we, input logic [7:0] d, input logic fa);
    logic [7:0] p = a[15:8];
    logic acc, e_iord, e_iowr, e_twr;
    @(negedge clk);
    req_addr = a; req_write = we; req_wdata = d; force_ack = fa; req_valid = 1'b1;
    timer_rdata = 16'($urandom);
    #1;
    acc = !m_lock;
    e_iord = acc && !we && p == 8'h00 && a[7:5] == 0;
    e_iowr = acc && we && p == 8'h00 && ((a[7:0] & 8'hE1) == 8'h01);
    e_twr  = acc && we && p == 8'h30;
    chk(io_rd_en == e_iord, "R1 io_rd_en", io_rd_en, e_iord);
    chk(io_wr_en == e_iowr, "R3 io_wr_en", io_wr_en, e_iowr);
    chk(timer_wr_en == e_twr, "R7 timer_wr_en", timer_wr_en, e_twr);
    if (e_iord || e_iowr) chk(io_index == a[4:1], "R1 io_index", io_index, a[4:1]);
    if (e_iowr) chk(io_wdata == d, "R3 io_wdata", io_wdata, d);
    if (e_twr) chk(timer_offset == a[7:0] && timer_wdata == d, "R7 timer write fields",
                   {timer_offset, timer_wdata}, {a[7:0], d});
    begin
      logic [7:0] e = exp_rd(a, timer_rdata);
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid == (acc && !we), "R11 rsp_valid", rsp_valid, acc && !we);
      if (acc && !we) chk(rsp_rdata == e, "R2 R7 R8 rsp_rdata", rsp_rdata, e);
    end
    if (acc && we) begin
      if (p == 8'h11 && !a[0]) m_breq = d[0];
      if (p == 8'h12 && !a[0]) m_rst = d[0];
      if (p == 8'h41 && a[0])  m_map = d[0];
    end
    if (acc && is_bad(p) && !fa) m_lock = 1'b1;
    check_latches("post");
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] pages [11] = '{8'h00, 8'h10, 8'h11, 8'h12, 8'h20, 8'h30, 8'h40, 8'h41, 8'h44, 8'h50, 8'h7E};
    void'($urandom(32'd1234));
    do_reset();
    // directed corner cases
    access(16'h0003, 1'b0, 8'h00, 1'b1);   // R1 io read
    access(16'h0020, 1'b0, 8'h00, 1'b1);   // R2 io hole even
    access(16'h0021, 1'b0, 8'h00, 1'b1);   // R2 io hole odd
    access(16'h0005, 1'b1, 8'hA5, 1'b1);   // R3 accepted
    access(16'h0004, 1'b1, 8'hA5, 1'b1);   // R3 even rejected
    access(16'h0041, 1'b1, 8'hA5, 1'b1);   // R3 high range rejected
    access(16'h1100, 1'b0, 8'h00, 1'b1);   // R4 read
    access(16'h1101, 1'b0, 8'h00, 1'b1);   // R2 odd busreq
    access(16'h1100, 1'b1, 8'h01, 1'b1);   // R4 latch 1
    access(16'h1101, 1'b1, 8'h00, 1'b1);   // R2 ignored
    access(16'h1202, 1'b1, 8'h01, 1'b1);   // R5 latch
    access(16'h1203, 1'b1, 8'h00, 1'b1);   // R5 odd ignored
    access(16'h4101, 1'b1, 8'h01, 1'b1);   // R6 map cart
    access(16'h4100, 1'b1, 8'h00, 1'b1);   // R6 even ignored
    access(16'h3000, 1'b0, 8'h00, 1'b1);   // R7 high byte
    access(16'h3001, 1'b0, 8'h00, 1'b1);   // R7 low byte
    access(16'h3033, 1'b1, 8'h5A, 1'b1);   // R7 write
    access(16'h4401, 1'b0, 8'h00, 1'b1);   // R2 reserved odd
    access(16'h9911, 1'b0, 8'h00, 1'b1);   // R9 bad w/ force
    access(16'h9910, 1'b1, 8'h00, 1'b0);   // R8 lock
    access(16'h0003, 1'b0, 8'h00, 1'b1);   // R8 refused while locked
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      int k = $urandom_range(0, 11);
      a[15:8] = (k == 11) ? 8'($urandom) : pages[k];
      a[7:0]  = ($urandom_range(0, 1) == 1) ? 8'($urandom) : 8'($urandom_range(0, 31));
      access(a, 1'($urandom), 8'($urandom), $urandom_range(0, 15) != 0);
      if (m_lock && $urandom_range(0, 3) == 0) do_reset();
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule